// File: doc/BRIEF.md
# Dual-Width ROM Read Interface

This block is the read side of a one-time-programmable word memory. It decodes a chip select, an output gate, a width select and a high-voltage identify flag into one operating mode each cycle, and drives a 16-bit data bus together with a per-bit drive-enable vector. The pad ring turns that vector into real tristate buffers. When the block is deselected it raises a standby flag. In byte-wide operation the top data pin turns into an extra low-order address input. That bit chooses which half of the addressed word appears on the low eight lanes.

An identify mode stands in for the array and returns fixed manufacturer and device codes. This lets programming equipment recognise the part. Identify is accepted only when the unrelated address lines are all low. Any other address pattern in identify mode is refused: the bus floats and an error flag is raised. The cell array sits inside the block and powers up erased. A direct preload port fills it for test setup. Every output is registered, so results follow the inputs by exactly one clock.

The array depth is a parameter. The default of 10 address bits keeps elaboration small. A setting of 16 gives the full 64K-word part.

Top module: `rom_dual_width_rd`

## Requirements
- R1: The array holds 2^ADDR_W words of 16 bits. After reset every word reads 0xFFFF until it is preloaded.
- R2: While `ce_n` is 1, whatever `oe_n`, `id_hv_i` and the address are doing, `dq_oe_o` and `dq_o` are all zeros, `standby_o` is 1 and `id_err_o` is 0.
- R3: While `ce_n` is 0 and `oe_n` is 1, `dq_oe_o` and `dq_o` are all zeros and both `standby_o` and `id_err_o` are 0.
- R4: In word mode (`wide_i` = 1) with `ce_n` = `oe_n` = 0 and no identify, `dq_o` is the word at `addr_i` and `dq_oe_o` is 0xFFFF. Bit 15 is driven as data, and `a_lsb_i` has no effect.
- R5: In byte mode (`wide_i` = 0) with both enables active, `dq_oe_o` is 0x00FF and `dq_o[15:8]` is 0. `dq_o[7:0]` carries word bits 15:8 when `a_lsb_i` = 1 and word bits 7:0 when `a_lsb_i` = 0.
- R6: With both enables active, `id_hv_i` = 1 and every address bit except bits 0 and 9 at 0, the source word is 0x00C2 when `addr_i[0]` = 0 and 0x0115 when `addr_i[0]` = 1. The value of bit 9 does not matter. The code is steered onto the bus as in R4 and R5.
- R7: The low byte of each identifier code holds an odd number of ones, with bit 7 serving as the parity bit.
- R8: With both enables active, `id_hv_i` = 1 and any address bit other than bits 0 and 9 set, `dq_oe_o` and `dq_o` are zeros and `id_err_o` is 1.
- R9: During reset and until the first capture, `dq_o` = 0, `dq_oe_o` = 0, `standby_o` = 1 and `id_err_o` = 0.
- R10: All outputs change only on the rising edge that samples new inputs. The inputs present before edge k decide the outputs after edge k.
- R11: A rising edge with `pl_we_i` = 1 writes `pl_data_i` into word `pl_addr_i`. Reads captured on later edges return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| wide_i | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| a_lsb_i | input | 1 | Shared pin seen as half-word select in byte mode |
| id_hv_i | input | 1 | High-voltage identify flag on address line 9 |
| addr_i | input | ADDR_W | Word address |
| pl_we_i | input | 1 | Preload write strobe |
| pl_addr_i | input | ADDR_W | Preload word address |
| pl_data_i | input | 16 | Preload word data |
| dq_o | output | 16 | Registered output data, zero on lanes that are not driven |
| dq_oe_o | output | 16 | Registered per-lane drive enables |
| standby_o | output | 1 | Registered deselect indication |
| id_err_o | output | 1 | Registered refused-identify indication |

## Verification
The hardest condition to reach from the ports is a refused identify. It needs both enables active and the identify flag set, and at the same time a stray address bit, which no ordinary read or identify would ever produce. The stimulus sets single stray bits at both ends of the checked range, 1 and 8, and sets bit 9 alone to show that it is exempt. Right after a refusal it issues a normal read to confirm that the error flag falls on the next capture. Byte-mode identify is also exercised, so the shared pin steers a code rather than array data.

// File: rtl/rom_if_pkg.sv
package rom_if_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_QUIET,
    MODE_READ,
    MODE_IDENT,
    MODE_ID_BAD
  } rd_mode_e;
endpackage

// File: rtl/rom_mode_dec.sv
module rom_mode_dec
  import rom_if_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ID_LINE  = 9,
  parameter int SEL_LINE = 0
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  output rd_mode_e          mode
);
  localparam logic [ADDR_W-1:0] ONE_A   = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] EXEMPT  = (ONE_A << ID_LINE) | (ONE_A << SEL_LINE);

  logic stray_bits;
  assign stray_bits = |(addr & ~EXEMPT);

  always_comb begin
    if (ce_n)            mode = MODE_STANDBY;
    else if (oe_n)       mode = MODE_QUIET;
    else if (!id_hv)     mode = MODE_READ;
    else if (stray_bits) mode = MODE_ID_BAD;
    else                 mode = MODE_IDENT;
  end
endmodule

// File: rtl/rom_cell_array.sv
module rom_cell_array #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/rom_out_steer.sv
module rom_out_steer
  import rom_if_pkg::*;
#(
  parameter logic [WORD_W-1:0] MFR_CODE = 16'h00C2,
  parameter logic [WORD_W-1:0] DEV_CODE = 16'h0115
) (
  input  rd_mode_e          mode,
  input  logic [WORD_W-1:0] cell_word,
  input  logic              wide,
  input  logic              a_lsb,
  input  logic              code_sel,
  output logic [WORD_W-1:0] nxt_data,
  output logic [WORD_W-1:0] nxt_en,
  output logic              nxt_stby,
  output logic              nxt_err
);
  logic [WORD_W-1:0] src_word;
  logic [HALF_W-1:0] half_pick;
  logic              drive;

  assign src_word  = (mode == MODE_IDENT) ? (code_sel ? DEV_CODE : MFR_CODE) : cell_word;
  assign half_pick = a_lsb ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];
  assign drive     = (mode == MODE_READ) || (mode == MODE_IDENT);

  always_comb begin
    nxt_data = '0;
    nxt_en   = '0;
    if (drive) begin
      if (wide) begin
        nxt_data = src_word;
        nxt_en   = '1;
      end else begin
        nxt_data[HALF_W-1:0] = half_pick;
        nxt_en[HALF_W-1:0]   = '1;
      end
    end
  end

  assign nxt_stby = (mode == MODE_STANDBY);
  assign nxt_err  = (mode == MODE_ID_BAD);
endmodule

// File: rtl/rom_dual_width_rd.sv
module rom_dual_width_rd
  import rom_if_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ID_LINE  = 9,
  parameter int SEL_LINE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              wide_i,
  input  logic              a_lsb_i,
  input  logic              id_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pl_we_i,
  input  logic [ADDR_W-1:0] pl_addr_i,
  input  logic [15:0]       pl_data_i,
  output logic [15:0]       dq_o,
  output logic [15:0]       dq_oe_o,
  output logic              standby_o,
  output logic              id_err_o
);
  localparam logic [ADDR_W-1:0] ONE_A  = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] EXEMPT = (ONE_A << ID_LINE) | (ONE_A << SEL_LINE);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  rd_mode_e          mode;
  logic [WORD_W-1:0] cell_word;
  logic [WORD_W-1:0] nxt_data, nxt_en;
  logic              nxt_stby, nxt_err;

  rom_mode_dec #(.ADDR_W(ADDR_W), .ID_LINE(ID_LINE), .SEL_LINE(SEL_LINE)) i_dec (
    .ce_n (ce_n),
    .oe_n (oe_n),
    .id_hv(id_hv_i),
    .addr (addr_i),
    .mode (mode)
  );

  rom_cell_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_cells (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (pl_we_i),
    .wr_addr(pl_addr_i),
    .wr_data(pl_data_i),
    .rd_addr(addr_i),
    .rd_data(cell_word)
  );

  rom_out_steer i_steer (
    .mode     (mode),
    .cell_word(cell_word),
    .wide     (wide_i),
    .a_lsb    (a_lsb_i),
    .code_sel (addr_i[SEL_LINE]),
    .nxt_data (nxt_data),
    .nxt_en   (nxt_en),
    .nxt_stby (nxt_stby),
    .nxt_err  (nxt_err)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dq_o      <= '0;
      dq_oe_o   <= '0;
      standby_o <= 1'b1;
      id_err_o  <= 1'b0;
    end else begin
      dq_o      <= nxt_data;
      dq_oe_o   <= nxt_en;
      standby_o <= nxt_stby;
      id_err_o  <= nxt_err;
    end
  end

  logic both_on, stray;
  assign both_on = !ce_n && !oe_n;
  assign stray   = |(addr_i & ~EXEMPT);

  assert_standby_hiz_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_n |=> (standby_o && dq_oe_o == '0 && dq_o == '0 && !id_err_o));

  assert_gate_off_hiz_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ce_n && oe_n) |=> (dq_oe_o == '0 && !standby_o && !id_err_o));

  assert_word_lanes_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (both_on && wide_i && !id_hv_i) |=> (dq_oe_o == 16'hFFFF));

  assert_byte_upper_off_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (both_on && !wide_i && !(id_hv_i && stray)) |=> (dq_oe_o == 16'h00FF && dq_o[15:8] == '0));

  assert_id_parity_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (both_on && wide_i && id_hv_i && !stray) |=> ($countones(dq_o[7:0]) % 2 == 1));

  assert_id_refuse_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (both_on && id_hv_i && stray) |=> (id_err_o && dq_oe_o == '0 && !standby_o));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(standby_o && id_err_o));
endmodule

// File: tb/test_rom_dual_width_rd.sv
module test_rom_dual_width_rd;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic ce_n, oe_n, wide_i, a_lsb_i, id_hv_i, pl_we_i;
  logic [AW-1:0] addr_i, pl_addr_i;
  logic [15:0] pl_data_i;
  logic [15:0] dq_o, dq_oe_o;
  logic standby_o, id_err_o;

  always #4 clk = ~clk;

  rom_dual_width_rd #(.ADDR_W(AW)) i_rom_dual_width_rd (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wide_i(wide_i),
    .a_lsb_i(a_lsb_i), .id_hv_i(id_hv_i), .addr_i(addr_i), .pl_we_i(pl_we_i),
    .pl_addr_i(pl_addr_i), .pl_data_i(pl_data_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .standby_o(standby_o), .id_err_o(id_err_o)
  );

  typedef struct {
    logic [15:0] d;
    logic [15:0] en;
    logic        sb;
    logic        er;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  logic [15:0] shadow [DEPTH];
  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  function automatic exp_t model(logic ce, logic oe, logic wd, logic lsb,
                                 logic hv, logic [AW-1:0] a, string tag);
    exp_t e;
    logic [15:0] src;
    logic [AW-1:0] stray_mask;
    e.d = '0; e.en = '0; e.sb = 1'b0; e.er = 1'b0; e.tag = tag;
    stray_mask = ~(AW'(1) | (AW'(1) << 9));
    if (ce) e.sb = 1'b1;
    else if (oe) e.sb = 1'b0;
    else if (hv && ((a & stray_mask) != '0)) e.er = 1'b1;
    else begin
      src = hv ? (a[0] ? 16'h0115 : 16'h00C2) : shadow[a];
      if (wd) begin e.d = src; e.en = 16'hFFFF; end
      else begin e.d = {8'h00, lsb ? src[15:8] : src[7:0]}; e.en = 16'h00FF; end
    end
    return e;
  endfunction

  task automatic compare(exp_t e, string what);
    checks++;
    if (dq_o !== e.d || dq_oe_o !== e.en || standby_o !== e.sb || id_err_o !== e.er) begin
      fails++;
      $display("FAIL %s %s: got d=%h en=%h sb=%b er=%b exp d=%h en=%h sb=%b er=%b",
               e.tag, what, dq_o, dq_oe_o, standby_o, id_err_o, e.d, e.en, e.sb, e.er);
    end
  endtask

  task automatic drive(logic ce, logic oe, logic wd, logic lsb, logic hv,
                       logic [AW-1:0] a, string tag, logic chk_hold = 1'b0);
    exp_t e;
    @(negedge clk);
    ce_n = ce; oe_n = oe; wide_i = wd; a_lsb_i = lsb; id_hv_i = hv; addr_i = a;
    e = model(ce, oe, wd, lsb, hv, a, tag);
    if (chk_hold) begin
      #1;
      compare(last_exp, "R10 hold before edge");
    end
    exp_q.push_back(e);
    last_exp = e;
  endtask

  task automatic preload(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    pl_we_i = 1'b1; pl_addr_i = a; pl_data_i = d;
    shadow[a] = d;
    @(negedge clk);
    pl_we_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      compare(e, "scoreboard");
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = 16'hFFFF;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; wide_i = 1'b1; a_lsb_i = 1'b0;
    id_hv_i = 1'b0; addr_i = '0; pl_we_i = 1'b0; pl_addr_i = '0; pl_data_i = '0;
    repeat (4) @(negedge clk);
    // R9: reset values
    begin
      exp_t r;
      r.d = '0; r.en = '0; r.sb = 1'b1; r.er = 1'b0; r.tag = "R9";
      compare(r, "in reset");
      rst_n = 1'b1;
      @(negedge clk); @(negedge clk);
      compare(r, "after release");
    end
    // R1: erased array
    drive(0, 0, 1, 0, 0, 10'd5, "R1");
    drive(0, 0, 1, 0, 0, 10'd1023, "R1");
    // R11: preload
    preload(10'd5, 16'hA5C3);
    preload(10'd1023, 16'h1234);
    preload(10'd0, 16'h8001);
    drive(0, 0, 1, 0, 0, 10'd5, "R11");
    // R4: word reads, shared pin ignored
    drive(0, 0, 1, 1, 0, 10'd5, "R4");
    drive(0, 0, 1, 0, 0, 10'd1023, "R4");
    drive(0, 0, 1, 1, 0, 10'd0, "R4");
    // R5: byte reads
    drive(0, 0, 0, 0, 0, 10'd5, "R5");
    drive(0, 0, 0, 1, 0, 10'd5, "R5");
    drive(0, 0, 0, 1, 0, 10'd1023, "R5");
    drive(0, 0, 0, 0, 0, 10'd0, "R5");
    // R2: standby dominates
    drive(1, 0, 1, 0, 0, 10'd5, "R2");
    drive(1, 1, 0, 1, 1, 10'd2, "R2");
    drive(1, 0, 1, 0, 1, 10'd0, "R2");
    // R3: gate off
    drive(0, 1, 1, 0, 0, 10'd5, "R3");
    drive(0, 1, 1, 0, 1, 10'd1, "R3");
    // R6: identify codes
    drive(0, 0, 1, 0, 1, 10'd0, "R6");
    drive(0, 0, 1, 0, 1, 10'd1, "R6");
    drive(0, 0, 1, 0, 1, 10'h201, "R6");
    drive(0, 0, 0, 1, 1, 10'd1, "R6");
    drive(0, 0, 0, 0, 1, 10'h200, "R6");
    // R7: parity of identifier low byte
    drive(0, 0, 1, 0, 1, 10'd1, "R6");
    @(posedge clk); #3;
    checks++;
    if ((^dq_o[7:0]) !== 1'b1) begin
      fails++;
      $display("FAIL R7 device code parity: got %h exp odd ones", dq_o[7:0]);
    end
    drive(0, 0, 1, 0, 1, 10'd0, "R6");
    @(posedge clk); #3;
    checks++;
    if ((^dq_o[7:0]) !== 1'b1) begin
      fails++;
      $display("FAIL R7 maker code parity: got %h exp odd ones", dq_o[7:0]);
    end
    // R8: refused identify
    drive(0, 0, 1, 0, 1, 10'h002, "R8");
    drive(0, 0, 1, 1, 1, 10'h100, "R8");
    drive(0, 0, 0, 0, 1, 10'h203, "R8");
    drive(0, 0, 1, 0, 0, 10'h100, "R8");
    // R10: outputs hold until the capturing edge
    drive(0, 0, 1, 0, 0, 10'd0, "R10");
    drive(1, 0, 1, 0, 0, 10'd0, "R10", 1'b1);
    drive(0, 0, 1, 0, 0, 10'd5, "R10", 1'b1);
    // R11: overwrite then read back
    preload(10'd512, 16'h7E18);
    drive(0, 0, 1, 0, 0, 10'd512, "R11");
    drive(0, 0, 0, 1, 0, 10'd512, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule